// File: doc/BRIEF.md
# I2C Target Engine with Selectable Clock-Stretch Point

This block is a bus target for a two-wire serial bus. It watches the clock and data lines through synchronizers, recognises START and STOP, compares the first byte after START with a 7-bit own address, and then moves bytes in either direction. It pulls a line low by raising an enable output, so the pads stay open-drain.

Local logic sets the pace by holding the clock low. This wait happens once per byte. A mode input places it either just after the falling edge of the eighth clock, before the acknowledge bit, or just after the falling edge of the ninth (acknowledge) clock. A wait lasts until local logic cancels it. It can do so with a one-cycle release pulse, or with a write to the data register, which also loads the next byte to send. When receiving, software writes all ones so that the data line stays free.

Top module: `i2c_wait_target`

## Requirements
- R1: After reset both line enables (`scl_oe`, `sda_oe`) and `wait_flag` are 0.
- R2: When the seven upper bits of the first byte after START differ from `own_addr`, the block leaves the data line released during the ninth clock. It does not stretch the clock and stays idle until the next START.
- R3: With `wait_sel`=0 and the address matched, the block holds the clock low from the falling edge of the eighth clock of every byte. It keeps it low even when the partner lets go. `wait_flag` is 1 during the hold, and the data line is released throughout.
- R4: With `wait_sel`=1 there is no hold after the eighth clock. The hold instead starts at the falling edge of the ninth clock and lasts until it is cancelled, with the data line released.
- R5: A matched address is always acknowledged with SDA low on the ninth clock. A received data byte is acknowledged with SDA low when `ack_en`=1 and left high (not acknowledged) when `ack_en`=0. In the eighth-clock mode, `ack_en` is taken at the moment the wait is cancelled.
- R6: A `wr_valid` pulse during a wait ends the hold within two cycles and loads `wr_data` as the next byte to transmit.
- R7: A `wait_release` pulse during a wait ends the hold within two cycles without changing the byte to transmit.
- R8: A received data byte appears on `rd_data` by the end of its eighth clock. The first bit on the bus is bit 7, and `rd_strobe` pulses for one cycle.
- R9: When the read/write bit (bit 0 of the address byte) is 1, the block sends the loaded byte bit 7 first. It changes SDA only while SCL is low. It ends the transfer and releases both lines if the controller answers a byte with SDA high on the ninth clock.
- R10: After a STOP both enables are 0, and clocked bytes are neither acknowledged nor stretched until a new START.
- R11: A repeated START, with no STOP before it, restarts address reception, including a change of direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Clock line as seen at the pad |
| sda_i | input | 1 | Data line as seen at the pad |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 7 | Address this target answers to |
| wait_sel | input | 1 | 0: hold after 8th clock, 1: hold after 9th clock |
| ack_en | input | 1 | Acknowledge received data bytes |
| wr_valid | input | 1 | Data register write strobe; cancels a wait |
| wr_data | input | 8 | Byte written to the data register |
| wait_release | input | 1 | One-cycle pulse that cancels a wait |
| rd_data | output | 8 | Last received data byte |
| rd_strobe | output | 1 | One-cycle pulse when rd_data is updated |
| wait_flag | output | 1 | 1 while the clock is being held low |

## Verification
The hardest case to reach is a hold in which the controller has already let go of the clock, so the line stays low only because this block drives it. The modelled controller therefore releases SCL during every expected wait, confirms that the wired line stays low for many cycles, and only then cancels the wait by the chosen method. Random transfers cover both modes, both release methods, both directions and address hits and misses. This exposes the ordering in the eighth-clock mode, where the acknowledge value and the byte to send are decided only after the wait ends.

// File: rtl/i2ct_pkg.sv
// Shared types for the I2C target engine.
// Assumes: one byte lane, seven-bit addressing.
package i2ct_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, lines released
        ST_BITS,   // clocks 1..8 of a byte
        ST_WAIT8,  // clock held after 8th falling edge
        ST_ACK,    // ninth clock
        ST_WAIT9   // clock held after 9th falling edge
    } i2ct_state_e;

    localparam logic WAIT_AT_8 = 1'b0;
    localparam logic WAIT_AT_9 = 1'b1;
endpackage

// File: rtl/i2ct_sync.sv
// Multi-flop synchronizer, one chain per input bit.
// Assumes: STAGES >= 2; idle level of the bus lines is 1, so the chains reset to 1.
module i2ct_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] pipe;
        // shift the asynchronous level through the chain
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/i2ct_bus_events.sv
// Turns synchronized line levels into one-cycle bus events:
// clock edges, START (data falls, clock high) and STOP (data rises, clock high).
// Assumes: inputs are already synchronized to clk.
module i2ct_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q;

    // remember the previous line levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_engine.sv
// Byte engine of the target: address compare, receive and transmit shifting,
// acknowledge generation and the clock-stretch wait at the selected point.
// Assumes: events come from i2ct_bus_events; SDA changes only on a detected
// clock fall or at a wait release, both while the clock is low.
module i2ct_engine
    import i2ct_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              wait_sel,
    input  logic              ack_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wait_release,
    output logic              scl_hold,
    output logic              sda_drv,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_strobe
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    i2ct_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] tx_buf;
    logic              addr_ph;
    logic              dir_tx;
    logic              nack;

    logic              addr_hit;
    logic              ack_drive;
    logic              release_req;
    logic              tx_next;
    logic [DATA_W-1:0] ld_val;

    // decode helpers for the state machine
    always_comb begin
        addr_hit    = (shreg[DATA_W-1 -: ADDR_W] == own_addr);
        ack_drive   = addr_ph ? 1'b1 : (dir_tx ? 1'b0 : ack_en);
        release_req = wait_release | wr_valid;
        tx_next     = addr_ph ? shreg[0] : dir_tx;
        ld_val      = wr_valid ? wr_data : tx_buf;
    end

    // bus protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            tx_buf    <= '1;
            addr_ph   <= 1'b0;
            dir_tx    <= 1'b0;
            nack      <= 1'b0;
            scl_hold  <= 1'b0;
            sda_drv   <= 1'b0;
            rd_data   <= '0;
            rd_strobe <= 1'b0;
        end else begin
            rd_strobe <= 1'b0;
            if (wr_valid) tx_buf <= wr_data;
            if (start_evt) begin
                state    <= ST_BITS;
                cnt      <= '0;
                addr_ph  <= 1'b1;
                dir_tx   <= 1'b0;
                scl_hold <= 1'b0;
                sda_drv  <= 1'b0;
            end else if (stop_evt) begin
                state    <= ST_IDLE;
                addr_ph  <= 1'b0;
                scl_hold <= 1'b0;
                sda_drv  <= 1'b0;
            end else begin
                case (state)
                    ST_BITS: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                            if (!dir_tx) shreg <= {shreg[DATA_W-2:0], sda_s};
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            if (addr_ph && !addr_hit) begin
                                state   <= ST_IDLE;
                                sda_drv <= 1'b0;
                            end else begin
                                if (!dir_tx && !addr_ph) begin
                                    rd_data   <= shreg;
                                    rd_strobe <= 1'b1;
                                end
                                if (wait_sel == WAIT_AT_8) begin
                                    state    <= ST_WAIT8;
                                    scl_hold <= 1'b1;
                                    sda_drv  <= 1'b0;
                                end else begin
                                    state   <= ST_ACK;
                                    sda_drv <= ack_drive;
                                end
                            end
                        end else if (scl_fall && dir_tx) begin
                            sda_drv <= ~shreg[DATA_W-2];
                            shreg   <= {shreg[DATA_W-2:0], 1'b0};
                        end
                    end
                    ST_WAIT8: begin
                        if (release_req) begin
                            scl_hold <= 1'b0;
                            state    <= ST_ACK;
                            sda_drv  <= ack_drive;
                        end
                    end
                    ST_ACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            sda_drv <= 1'b0;
                            addr_ph <= 1'b0;
                            dir_tx  <= tx_next;
                            if (!addr_ph && dir_tx && nack) begin
                                state <= ST_IDLE;
                            end else if (wait_sel == WAIT_AT_9) begin
                                state    <= ST_WAIT9;
                                scl_hold <= 1'b1;
                            end else begin
                                state <= ST_BITS;
                                cnt   <= '0;
                                if (tx_next) begin
                                    shreg   <= tx_buf;
                                    sda_drv <= ~tx_buf[DATA_W-1];
                                end
                            end
                        end
                    end
                    ST_WAIT9: begin
                        if (release_req) begin
                            scl_hold <= 1'b0;
                            state    <= ST_BITS;
                            cnt      <= '0;
                            if (dir_tx) begin
                                shreg   <= ld_val;
                                sda_drv <= ~ld_val[DATA_W-1];
                            end
                        end
                    end
                    default: begin
                        scl_hold <= 1'b0;
                        sda_drv  <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_wait_target.sv
// Top of the I2C target: synchronizes the pads, derives bus events and runs
// the byte engine. Outputs are open-drain enables (1 = pull the line low).
// Assumes: pads are wired-AND with external pull-ups; the clock low phase
// spans more than SYNC_STAGES + 2 system clocks.
module i2c_wait_target #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              wait_sel,
    input  logic              ack_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wait_release,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_strobe,
    output logic              wait_flag
);
    logic [1:0] lines_s;
    logic       scl_rise, scl_fall, start_evt, stop_evt;
    logic       scl_hold, sda_drv;

    i2ct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({scl_i, sda_i}),
        .q_o  (lines_s)
    );

    i2ct_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2ct_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .sda_s       (lines_s[0]),
        .own_addr    (own_addr),
        .wait_sel    (wait_sel),
        .ack_en      (ack_en),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wait_release(wait_release),
        .scl_hold    (scl_hold),
        .sda_drv     (sda_drv),
        .rd_data     (rd_data),
        .rd_strobe   (rd_strobe)
    );

    assign scl_oe    = scl_hold;
    assign sda_oe    = sda_drv;
    assign wait_flag = scl_hold;
endmodule

// File: rtl/i2ct_checker.sv
// Protocol properties of the I2C target, attached to the top by bind.
// Assumes: rst_n is synchronous and active low.
module i2ct_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic wait_release,
    input logic wr_valid,
    input logic stop_evt
);
    AST_HOLD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_i); // R3
    AST_SDA_FREE_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !sda_oe); // R3
    AST_HOLD_ENDS_BY_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> $past(wait_release || wr_valid)); // R6
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i); // R9
    AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!scl_oe && !sda_oe)); // R10
endmodule

bind i2c_wait_target i2ct_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .wait_release(wait_release),
    .wr_valid    (wr_valid),
    .stop_evt    (stop_evt)
);

// File: tb/test_i2c_wait_target.sv
// Bench: a modelled bus controller with clock-stretch support drives random
// and directed transfers; expectations come from the requirements.
module test_i2c_wait_target;
    localparam int H = 12;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic       wait_sel = 1'b0, ack_en = 1'b1, wr_valid = 1'b0, wait_release = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       scl_oe, sda_oe, rd_strobe, wait_flag;
    logic [7:0] rd_data;
    wire        scl_line = !(m_scl_low | scl_oe);
    wire        sda_line = !(m_sda_low | sda_oe);

    int         errs = 0, checks = 0;
    logic [7:0] tx_model = 8'hFF;

    i2c_wait_target i_i2c_wait_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .wait_sel(wait_sel),
        .ack_en(ack_en), .wr_valid(wr_valid), .wr_data(wr_data),
        .wait_release(wait_release), .rd_data(rd_data), .rd_strobe(rd_strobe),
        .wait_flag(wait_flag)
    );

    function automatic logic exp_ack_low(input logic is_addr, input logic en);
        return is_addr ? 1'b1 : en;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        int t = 0;
        while (!scl_line && t < 5000) begin tick(1); t++; end
        if (t >= 5000) chk(1'b0, "R6", "clock never released", 0, 1);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda_low = !b; tick(H);
        m_scl_low = 1'b0; wait_scl_high(); tick(H);
        s = sda_line;
        m_scl_low = 1'b1; tick(H);
    endtask

    task automatic do_start();
        m_sda_low = 1'b0; tick(H);
        m_scl_low = 1'b0; wait_scl_high(); tick(H);
        m_sda_low = 1'b1; tick(H);
        m_scl_low = 1'b1; tick(H);
    endtask

    task automatic do_stop();
        m_sda_low = 1'b1; tick(H);
        m_scl_low = 1'b0; wait_scl_high(); tick(H);
        m_sda_low = 1'b0; tick(H);
    endtask

    // called with the clock low after a byte or ACK clock
    task automatic wait_step(input logic expect_w, input string req,
                             input logic use_wr, input logic [7:0] wv);
        m_sda_low = 1'b0; tick(6);
        if (expect_w) begin
            chk(wait_flag == 1'b1, req, "wait flag", wait_flag, 1);
            chk(sda_oe == 1'b0, req, "sda free in wait", sda_oe, 0);
            m_scl_low = 1'b0; tick(40);
            chk(scl_line == 1'b0, req, "clock held after partner release", scl_line, 0);
            m_scl_low = 1'b1; tick(2);
            if (use_wr) begin
                wr_data = wv; wr_valid = 1'b1; tick(1); wr_valid = 1'b0; tx_model = wv;
                tick(2);
                chk(wait_flag == 1'b0, "R6", "write cancels wait", wait_flag, 0);
            end else begin
                wait_release = 1'b1; tick(1); wait_release = 1'b0;
                tick(2);
                chk(wait_flag == 1'b0, "R7", "release cancels wait", wait_flag, 0);
            end
        end else begin
            chk(wait_flag == 1'b0, req, "no wait expected", wait_flag, 0);
        end
    endtask

    task automatic xfer(input logic [6:0] a, input logic rw, input int n,
                        input logic mode, input logic use_wr, input logic do_end);
        logic [7:0] d[5];
        logic [7:0] abyte, rb, exp;
        logic s, hit, last;
        for (int i = 0; i < 5; i++) d[i] = 8'($urandom);
        wait_sel = mode;
        abyte = {a, rw};
        hit = (a == OWN);
        do_start();
        for (int i = 7; i >= 0; i--) clk_bit(abyte[i], s);
        wait_step(hit && mode == 1'b0, "R3", use_wr, rw ? d[0] : 8'hFF);
        clk_bit(1'b1, s);
        if (!hit) begin
            chk(s == 1'b1, "R2", "mismatch not acked", s, 1);
            tick(6);
            chk(wait_flag == 1'b0 && sda_oe == 1'b0, "R2", "idle after mismatch",
                {wait_flag, sda_oe}, 0);
            do_stop();
            return;
        end
        chk(s == !exp_ack_low(1'b1, ack_en), "R5", "address ack", s, 0);
        wait_step(mode == 1'b1, "R4", use_wr, rw ? d[0] : 8'hFF);
        for (int k = 0; k < n; k++) begin
            last = (k == n - 1);
            exp = tx_model;
            if (rw) begin
                for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); rb[i] = s; end
                chk(rb == exp, "R9", "transmitted byte", rb, exp);
            end else begin
                for (int i = 7; i >= 0; i--) clk_bit(d[k][i], s);
            end
            wait_step(mode == 1'b0, "R3", use_wr, rw ? d[k+1] : 8'hFF);
            if (!rw) chk(rd_data == d[k], "R8", "received byte", rd_data, d[k]);
            if (rw) begin
                clk_bit(last, s);
            end else begin
                clk_bit(1'b1, s);
                chk(s == !exp_ack_low(1'b0, ack_en), "R5", "data ack", s, !ack_en);
            end
            wait_step(mode == 1'b1 && !(rw && last), "R4", use_wr, rw ? d[k+1] : 8'hFF);
            if (rw && last) chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R9",
                                "released after nack", {scl_oe, sda_oe}, 0);
        end
        if (do_end) begin
            do_stop();
            tick(6);
            chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R10", "idle after stop",
                {scl_oe, sda_oe}, 0);
        end
    endtask

    initial begin
        logic s;
        logic [7:0] pat;
        void'($urandom(32'h00C0FFEE));
        tick(5);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0 && wait_flag == 1'b0, "R1",
            "reset outputs", {scl_oe, sda_oe, wait_flag}, 0);
        rst_n = 1'b1; tick(5);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "after reset release",
            {scl_oe, sda_oe}, 0);

        // directed: each mode, each direction, each release method
        ack_en = 1'b1;
        xfer(OWN, 1'b0, 2, 1'b0, 1'b1, 1'b1);
        xfer(OWN, 1'b0, 2, 1'b1, 1'b0, 1'b1);
        xfer(OWN, 1'b1, 2, 1'b0, 1'b1, 1'b1);
        xfer(OWN, 1'b1, 2, 1'b1, 1'b0, 1'b1);
        ack_en = 1'b0;
        xfer(OWN, 1'b0, 1, 1'b1, 1'b1, 1'b1);
        xfer(OWN ^ 7'h01, 1'b0, 1, 1'b0, 1'b0, 1'b1);

        // R10: bytes after a STOP without START are ignored
        pat = {OWN, 1'b0};
        for (int i = 7; i >= 0; i--) clk_bit(pat[i], s);
        tick(6);
        chk(wait_flag == 1'b0, "R10", "no wait without start", wait_flag, 0);
        clk_bit(1'b1, s);
        chk(s == 1'b1, "R10", "no ack without start", s, 1);
        do_stop();

        // R11: write then repeated START into a read
        ack_en = 1'b1;
        xfer(OWN, 1'b0, 1, 1'b1, 1'b0, 1'b0);
        xfer(OWN, 1'b1, 1, 1'b1, 1'b1, 1'b1);
        chk(sda_oe == 1'b0, "R11", "repeated start transfer ended clean", sda_oe, 0);

        // random mix
        for (int t = 0; t < 28; t++) begin
            logic [6:0] a;
            a = ($urandom % 4 != 0) ? OWN : (OWN ^ 7'(1 + $urandom % 127));
            ack_en = 1'($urandom);
            xfer(a, 1'($urandom), 1 + int'($urandom % 3), 1'($urandom),
                 1'($urandom), 1'b1);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        tick(190000);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule